// File: doc/BRIEF.md
# Sum-Indexed Dual-Bank Wordline Decoder

This block selects SRAM rows for a load whose address is the sum of a base register and a signed or unsigned offset. It does not add the two operands and then decode the result. Each bit position of the two operands drives a small set of comparison wires, and every row of the array has them in common. Each row picks one wire per bit, using the constant bits of its own line number, and ANDs the picks together. The carry chain that a full adder would need is never built on the decode path.

The doubleword index is byte-address bits [ADDR_W-1:LINE_LSB]. The lines are split by index parity into an even bank and an odd bank, and each bank has half the rows. The carry out of the in-line byte bits can move the real line up by one. For that reason, the block raises one row in each bank so that both the partial-sum index I and I+1 are fetched. The carry from the low bits then picks between the two banks later, outside this block. The wordlines are registered once, so they follow the operands by one clock.

Top module: `sum_addr_decoder`

## Requirements
- R1: While `rst` is sampled high at a rising edge, both wordline vectors read all zeros after that edge.
- R2: Outside reset, exactly one bit of `wl_even_o` and exactly one bit of `wl_odd_o` are high.
- R3: Let I = (base[ADDR_W-1:LINE_LSB] + offs[ADDR_W-1:LINE_LSB]) modulo 2^(ADDR_W-LINE_LSB). Odd-bank bit n holds line 2n+1, and it is high exactly when I equals 2n or 2n+1.
- R4: Even-bank bit n holds line 2n, and it is high exactly when I equals 2n or 2n-1, counted modulo 2^(ADDR_W-LINE_LSB). Even bit 0 is therefore high when I is all ones.
- R5: Let the true line be bits [ADDR_W-1:LINE_LSB] of the full byte sum base+offs, taken modulo 2^ADDR_W. If it is even, even-bank bit (line/2) is high. If it is odd, odd-bank bit (line/2) is high.
- R6: Bits [LINE_LSB-1:0] of `base_i` and `offs_i` have no effect on either wordline vector.
- R7: Each wordline vector reflects the operands sampled at the previous rising edge. A change in the operands between edges does not show on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | ADDR_W | Base register operand (byte address) |
| offs_i | input | ADDR_W | Offset operand (byte address) |
| wl_even_o | output | 2^(ADDR_W-LINE_LSB-1) | Registered one-hot wordlines of the even-line bank |
| wl_odd_o | output | 2^(ADDR_W-LINE_LSB-1) | Registered one-hot wordlines of the odd-line bank |

## Verification
The assertions assume that `rst` is held through at least one rising edge before any check counts. They also assume that the operands are meaningful at every edge once reset is released. A shadow flag keeps the row checks idle until the first operands outside reset have been captured. The bench builds the block with a 7-bit address, which gives 8 rows per bank. It drives every base and offset pair, so every carry pattern is covered, including the wrap from the all-ones index into even row 0. Reset is applied only between drained runs, so no queued expectation spans a reset.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Per-bit comparison wires shared by every row of both banks.
  // The name gives which neighbour-carry term is folded in and its polarity.
  typedef struct packed {
    logic and_t;  // sum bit xor (and of lower bits)
    logic or_t;   // sum bit xor (or of lower bits)
    logic and_n;  // inverse of and_t
    logic or_n;   // inverse of or_t
  } sad_wires_t;

endpackage

// File: rtl/sad_wire_gen.sv
module sad_wire_gen
  import sad_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int LINE_LSB = 3,
  localparam int NBITS   = ADDR_W - LINE_LSB - 1
) (
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [ADDR_W-1:0]        offs_i,
  output sad_wires_t [NBITS-1:0]   wires_o
);

  // Bit k of the wire bundle sits at byte position LINE_LSB+1+k. The carry into it
  // comes from the position below, which carries a constant ~L bit per row.
  for (genvar k = 0; k < NBITS; k++) begin : g_bit
    localparam int P = LINE_LSB + 1 + k;
    logic half_x;
    logic w_and;
    logic w_or;
    assign half_x = base_i[P] ^ offs_i[P];
    assign w_and  = half_x ^ (base_i[P-1] & offs_i[P-1]);
    assign w_or   = half_x ^ (base_i[P-1] | offs_i[P-1]);
    assign wires_o[k].and_t = w_and;
    assign wires_o[k].or_t  = w_or;
    assign wires_o[k].and_n = ~w_and;
    assign wires_o[k].or_n  = ~w_or;
  end

endmodule

// File: rtl/sad_row_match.sv
module sad_row_match
  import sad_pkg::*;
#(
  parameter int NBITS    = 10,
  parameter int ROW_LINE = 0,
  localparam int LINE_W  = NBITS + 1
) (
  input  sad_wires_t [NBITS-1:0] wires_i,
  output logic                   hit_o
);

  localparam logic [LINE_W-1:0] LV = ROW_LINE[LINE_W-1:0];

  logic [NBITS-1:0] pick;

  // The constant line bits at k+1 and k choose one of the four wires for this row.
  for (genvar k = 0; k < NBITS; k++) begin : g_pick
    if (LV[k+1] && LV[k]) begin : g_11
      assign pick[k] = wires_i[k].and_t;
    end else if (LV[k+1]) begin : g_10
      assign pick[k] = wires_i[k].or_t;
    end else if (LV[k]) begin : g_01
      assign pick[k] = wires_i[k].and_n;
    end else begin : g_00
      assign pick[k] = wires_i[k].or_n;
    end
  end

  assign hit_o = &pick;

endmodule

// File: rtl/sad_bank.sv
module sad_bank
  import sad_pkg::*;
#(
  parameter int NBITS   = 10,
  parameter int PARITY  = 0,
  localparam int ROWS   = 1 << NBITS
) (
  input  sad_wires_t [NBITS-1:0] wires_i,
  output logic [ROWS-1:0]        wl_o
);

  for (genvar n = 0; n < ROWS; n++) begin : g_row
    sad_row_match #(
      .NBITS    (NBITS),
      .ROW_LINE (2 * n + PARITY)
    ) u_row (
      .wires_i (wires_i),
      .hit_o   (wl_o[n])
    );
  end

endmodule

// File: rtl/sum_addr_decoder.sv
module sum_addr_decoder
  import sad_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int LINE_LSB  = 3,
  localparam int IDX_W    = ADDR_W - LINE_LSB,
  localparam int NBITS    = IDX_W - 1,
  localparam int BANK_ROWS = 1 << NBITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    offs_i,
  output logic [BANK_ROWS-1:0] wl_even_o,
  output logic [BANK_ROWS-1:0] wl_odd_o
);

  sad_wires_t [NBITS-1:0] wires;
  logic [BANK_ROWS-1:0]   even_hit;
  logic [BANK_ROWS-1:0]   odd_hit;

  sad_wire_gen #(
    .ADDR_W   (ADDR_W),
    .LINE_LSB (LINE_LSB)
  ) u_wires (
    .base_i  (base_i),
    .offs_i  (offs_i),
    .wires_o (wires)
  );

  sad_bank #(.NBITS(NBITS), .PARITY(0)) u_even (
    .wires_i (wires),
    .wl_o    (even_hit)
  );

  sad_bank #(.NBITS(NBITS), .PARITY(1)) u_odd (
    .wires_i (wires),
    .wl_o    (odd_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_even_o <= '0;
      wl_odd_o  <= '0;
    end else begin
      wl_even_o <= even_hit;
      wl_odd_o  <= odd_hit;
    end
  end

  // Shadow model for the checks: a carrying adder and a captured index.
  logic                vld_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    line_q;
  logic [IDX_W-1:0]    idx_up;
  logic [ADDR_W-1:0]   full_sum;

  assign full_sum = base_i + offs_i;
  assign idx_up   = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      line_q <= '0;
    end else begin
      vld_q  <= 1'b1;
      idx_q  <= base_i[ADDR_W-1:LINE_LSB] + offs_i[ADDR_W-1:LINE_LSB];
      line_q <= full_sum[ADDR_W-1:LINE_LSB];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (wl_even_o == '0 && wl_odd_o == '0))
    else $error("reset did not clear wordlines");

  p_even_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ($countones(wl_even_o) == 1))
    else $error("even bank not one-hot");

  p_odd_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ($countones(wl_odd_o) == 1))
    else $error("odd bank not one-hot");

  p_odd_row_r3: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> wl_odd_o[idx_q[IDX_W-1:1]])
    else $error("odd bank row does not cover index");

  p_even_row_r4: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> wl_even_o[idx_up[IDX_W-1:1]])
    else $error("even bank row does not cover index plus one");

  p_true_line_r5: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (line_q[0] ? wl_odd_o[line_q[IDX_W-1:1]]
                         : wl_even_o[line_q[IDX_W-1:1]]))
    else $error("true line not selected");

endmodule

// File: tb/tb_sum_addr_decoder.sv
module tb_sum_addr_decoder;

  localparam int CLK_P = 10;
  localparam int AW    = 7;
  localparam int LSB   = 3;
  localparam int IW    = AW - LSB;
  localparam int NR    = 1 << (IW - 1);
  localparam int IMOD  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] offs = '0;
  logic [NR-1:0] wl_even;
  logic [NR-1:0] wl_odd;

  always #(CLK_P / 2) clk = ~clk;

  sum_addr_decoder #(.ADDR_W(AW), .LINE_LSB(LSB)) dut (
    .clk       (clk),
    .rst       (rst),
    .base_i    (base),
    .offs_i    (offs),
    .wl_even_o (wl_even),
    .wl_odd_o  (wl_odd)
  );

  typedef struct {
    int            r;
    int            o;
    logic [NR-1:0] exp_e;
    logic [NR-1:0] exp_o;
    bit            low_only;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    closed = 1'b0;

  function automatic int idx_of(int r, int o);
    return ((r >> LSB) + (o >> LSB)) % IMOD;
  endfunction

  function automatic logic [NR-1:0] exp_odd_f(int r, int o);
    logic [NR-1:0] v = '0;
    v[idx_of(r, o) >> 1] = 1'b1;
    return v;
  endfunction

  function automatic logic [NR-1:0] exp_even_f(int r, int o);
    logic [NR-1:0] v = '0;
    v[((idx_of(r, o) + 1) % IMOD) >> 1] = 1'b1;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!closed) begin
      closed = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Driver: applies operands on the falling edge and queues what must appear.
  task automatic drive(int r, int o, bit low_only);
    item_t it;
    @(negedge clk);
    base = AW'(r);
    offs = AW'(o);
    it.r = r;
    it.o = o;
    // Expectations use only the bits above LSB, so low bits are ignored (R6).
    it.exp_e = exp_even_f(r, o);
    it.exp_o = exp_odd_f(r, o);
    it.low_only = low_only;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  // Monitor: one register stage, so results are compared just after the next rising edge.
  initial begin
    item_t it;
    int    line;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.low_only) begin
          check(wl_even == it.exp_e && wl_odd == it.exp_o, "R6 low bits",
                {wl_even, wl_odd}, {it.exp_e, it.exp_o});
        end else begin
          check(wl_odd == it.exp_o, "R3 odd bank", wl_odd, it.exp_o);
          check(wl_even == it.exp_e, "R4 even bank", wl_even, it.exp_e);
          check($countones(wl_even) == 1 && $countones(wl_odd) == 1, "R2 one-hot",
                {wl_even, wl_odd}, 1);
          line = (((it.r + it.o) % (1 << AW)) >> LSB);
          if (line % 2 == 1)
            check(wl_odd[line >> 1] == 1'b1, "R5 true line odd", wl_odd, line);
          else
            check(wl_even[line >> 1] == 1'b1, "R5 true line even", wl_even, line);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    @(posedge clk);
    #1;
    check(wl_even == '0 && wl_odd == '0, "R1 reset", {wl_even, wl_odd}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R4 wrap corner: all-ones index selects even row 0.
    drive((IMOD - 1) << LSB, 0, 1'b0);
    drive(((IMOD / 2) << LSB) | 7, ((IMOD / 2 - 1) << LSB) | 1, 1'b0);

    // R7: the output keeps the previous operands until the next edge.
    drain();
    drive(1 << LSB, 0, 1'b0);
    drive(4 << LSB, 2 << LSB, 1'b0);
    #1;
    check(wl_even == exp_even_f(1 << LSB, 0) && wl_odd == exp_odd_f(1 << LSB, 0),
          "R7 latency", {wl_even, wl_odd},
          {exp_even_f(1 << LSB, 0), exp_odd_f(1 << LSB, 0)});
    drain();

    // R3, R4, R2, R5: every operand pair.
    for (int r = 0; r < (1 << AW); r++)
      for (int o = 0; o < (1 << AW); o++)
        drive(r, o, 1'b0);
    drain();

    // R6: sweep the in-line byte bits under fixed upper bits.
    for (int p = 0; p < 4; p++)
      for (int lo = 0; lo < 64; lo++)
        drive(((p * 5 + 3) % IMOD << LSB) | (lo & 7),
              ((p * 3 + 6) % IMOD << LSB) | (lo >> 3), 1'b1);
    drain();

    // R1: reset mid-run with live operands clears both banks.
    @(negedge clk);
    rst  = 1'b1;
    base = AW'(7'h5a);
    offs = AW'(7'h33);
    @(posedge clk);
    #1;
    check(wl_even == '0 && wl_odd == '0, "R1 mid-run reset", {wl_even, wl_odd}, 0);
    @(posedge clk);
    #1;
    check(wl_even == '0 && wl_odd == '0, "R1 held reset", {wl_even, wl_odd}, 0);
    @(negedge clk);
    rst = 1'b0;
    drive(7'h5a, 7'h33, 1'b0);
    drain();

    finish_run();
  end

endmodule